// File: doc/BRIEF.md
# Hot-Swap I2C Segment Connect Controller

This block guards a plug-in card's I2C segment against a live backplane I2C segment. After supply comes good it keeps the two segments apart. It waits until the backplane shows that any transfer in flight has ended, either through a stop condition or a sustained idle period. It then confirms that the card's own SDA and SCL both read high. Only when both conditions hold does it join the segments.

Once joined, each line (SDA and SCL, handled independently) behaves as one wired-AND net spanning both sides. An external low on either side produces a pull-down request on the opposite side. The line returns high only after every driver on both sides has let go. This keeps clock stretching, clock synchronisation, arbitration and acknowledge intact wherever the devices sit.

All four bus inputs are synchronised through a flop chain before use. The pull-down outputs are meant to drive open-drain pads.

The connection state machine has four states:
- CN_LOCKOUT: supply not good; all bus activity ignored.
- CN_WAIT_FREE: waiting for a backplane stop or idle.
- CN_CHECK_CARD: backplane free; waiting for both card lines high.
- CN_LINKED: segments joined.

The connection transitions are:
- any state to CN_LOCKOUT when supply-good is low;
- CN_LOCKOUT to CN_WAIT_FREE when supply-good is high;
- CN_WAIT_FREE to CN_CHECK_CARD on a stop or idle;
- CN_CHECK_CARD to CN_WAIT_FREE when either backplane line goes low;
- CN_CHECK_CARD to CN_LINKED when both card lines are high.

Each line has its own join state machine with four states:
- LN_FREE: no low owned.
- LN_BP_HELD: the backplane side is pulling low, so the card side is pulled.
- LN_CD_HELD: the card side is pulling low, so the backplane side is pulled.
- LN_BLANK: a short hold-off after a release, so that the block's own fading pull-down is not mistaken for an external low.

The line transitions are:
- LN_FREE to LN_BP_HELD on a backplane low, which wins a tie;
- LN_FREE to LN_CD_HELD on a card low;
- a held state to LN_BLANK when its owning side reads high;
- LN_BLANK to LN_FREE after SYNC_STAGES+1 cycles;
- any state to LN_FREE when the join is disabled.

Top module: `hs_bus_connect`

## Requirements
- R1: While `pwr_good` is low, `link_en` and all four pull-down outputs are 0, and bus activity during that time (including stop conditions) is not remembered after `pwr_good` rises.
- R2: After leaving lockout with the backplane busy (SCL low), `link_en` stays 0 until a backplane stop (SDA rising while SCL high) is seen.
- R3: Backplane idle means SDA and SCL both synchronised high for IDLE_CYCLES consecutive cycles, counted by a saturating counter that any low clears and that is held clear in lockout; idle alone permits connection.
- R4: `link_en` rises only when the card-side SDA and SCL are both sampled high; a low card line holds off connection until it is released.
- R5: If a backplane line goes low while waiting for the card lines, the stop/idle qualification is discarded and a fresh stop or idle is needed.
- R6: When linked, an external low on backplane SDA or SCL sets the matching card-side pull-down, and an external low on the card side sets the matching backplane pull-down.
- R7: When linked, each line's steady level on both sides equals the AND of the external drivers on both sides; SDA and SCL are independent.
- R8: The block's own pull-down never latches a line: after all external drivers release, both sides return high and all pull-downs are 0.
- R9: A drop of `pwr_good` while linked clears `link_en` and all pull-downs in the same cycle, and reconnection again requires stop/idle and card readiness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Synchronous supply-good flag |
| bp_sda_i | input | 1 | Backplane SDA level |
| bp_scl_i | input | 1 | Backplane SCL level |
| cd_sda_i | input | 1 | Card-side SDA level |
| cd_scl_i | input | 1 | Card-side SCL level |
| link_en | output | 1 | Segments joined |
| bp_sda_pd | output | 1 | Pull-down request, backplane SDA |
| bp_scl_pd | output | 1 | Pull-down request, backplane SCL |
| cd_sda_pd | output | 1 | Pull-down request, card SDA |
| cd_scl_pd | output | 1 | Pull-down request, card SCL |

## Verification
The bench targets the following corner cases:
- A stop seen during lockout, which a design that did not ignore lockout activity would remember and use to connect early.
- A long idle that starts during lockout, which a timer left running would turn into an instant connection.
- A card line held low.
- A new backplane transfer starting during the card check, which a design without the fallback would join mid-transfer.
- Overlapping lows from both sides under random drivers, where a design that counted its own pull-down as an external low would leave the bus stuck low.
- A supply drop mid-transfer, which must release every pull-down at once.

// File: rtl/hs_conn_pkg.sv
package hs_conn_pkg;

    typedef enum logic [1:0] {
        CN_LOCKOUT,
        CN_WAIT_FREE,
        CN_CHECK_CARD,
        CN_LINKED
    } conn_state_e;

    typedef enum logic [1:0] {
        LN_FREE,
        LN_BP_HELD,
        LN_CD_HELD,
        LN_BLANK
    } line_state_e;

    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_idle_timer.sv
module hs_idle_timer #(
    parameter int IDLE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sda,
    input  logic scl,
    output logic idle
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (clear || !sda || !scl) cnt <= '0;
        else if (cnt != LIMIT)        cnt <= cnt + 1'b1;
    end

    assign idle = (cnt == LIMIT);

    // R3: a low on either line or a clear removes the idle qualification
    a_r3_low_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || !sda || !scl) |=> !idle);
endmodule

// File: rtl/hs_line_join.sv
module hs_line_join
    import hs_conn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bp_lvl,
    input  logic cd_lvl,
    output logic pd_bp,
    output logic pd_cd
);
    localparam int BLANK_CYCLES = SYNC_STAGES + 1;
    localparam int BW = $clog2(BLANK_CYCLES + 1);
    localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYCLES - 1);

    line_state_e st, st_nxt;
    logic [BW-1:0] blank_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= LN_FREE;
            blank_cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st_nxt == LN_BLANK && st != LN_BLANK) blank_cnt <= '0;
            else if (st == LN_BLANK)                  blank_cnt <= blank_cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        if (!en) begin
            st_nxt = LN_FREE;
        end else begin
            unique case (st)
                LN_FREE: begin
                    if (!bp_lvl)      st_nxt = LN_BP_HELD;
                    else if (!cd_lvl) st_nxt = LN_CD_HELD;
                end
                LN_BP_HELD: if (bp_lvl) st_nxt = LN_BLANK;
                LN_CD_HELD: if (cd_lvl) st_nxt = LN_BLANK;
                LN_BLANK:   if (blank_cnt == BLANK_LAST) st_nxt = LN_FREE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pd_bp = en && (st == LN_CD_HELD);
        pd_cd = en && (st == LN_BP_HELD);
    end

    // R6: backplane low while free pulls the card side next cycle
    a_r6_bp_low_to_cd: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == LN_FREE && !bp_lvl) |=> (pd_cd || !en));
    // R6: card low while free pulls the backplane side next cycle
    a_r6_cd_low_to_bp: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == LN_FREE && bp_lvl && !cd_lvl) |=> (pd_bp || !en));
    // R7: pull persists while the owning side still reads low
    a_r7_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == LN_BP_HELD && !bp_lvl) |=> (pd_cd || !en));
    // R8: after a release the line is never re-pulled in the next cycle
    a_r8_no_self_relatch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_cd) |=> !pd_bp);
endmodule

// File: rtl/hs_bus_connect.sv
module hs_bus_connect
    import hs_conn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    output logic link_en,
    output logic bp_sda_pd,
    output logic bp_scl_pd,
    output logic cd_sda_pd,
    output logic cd_scl_pd
);
    logic [NUM_LINES-1:0] bp_s, cd_s, pd_bp, pd_cd;
    logic bp_sda_prev;
    logic stop_seen, bp_idle, in_lockout;
    conn_state_e state, state_nxt;

    hs_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_LINES)) u_bp_sync (
        .clk(clk), .rst_n(rst_n), .d({bp_scl_i, bp_sda_i}), .q(bp_s));
    hs_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_LINES)) u_cd_sync (
        .clk(clk), .rst_n(rst_n), .d({cd_scl_i, cd_sda_i}), .q(cd_s));

    // stop detection on the backplane
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bp_sda_prev <= 1'b1;
        else        bp_sda_prev <= bp_s[LINE_SDA];
    end
    assign stop_seen = bp_s[LINE_SDA] && !bp_sda_prev && bp_s[LINE_SCL];

    assign in_lockout = (state == CN_LOCKOUT);

    hs_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk(clk), .rst_n(rst_n), .clear(in_lockout),
        .sda(bp_s[LINE_SDA]), .scl(bp_s[LINE_SCL]), .idle(bp_idle));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CN_LOCKOUT;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (!pwr_good) begin
            state_nxt = CN_LOCKOUT;
        end else begin
            unique case (state)
                CN_LOCKOUT:    state_nxt = CN_WAIT_FREE;
                CN_WAIT_FREE:  if (stop_seen || bp_idle) state_nxt = CN_CHECK_CARD;
                CN_CHECK_CARD: begin
                    if (bp_s != 2'b11)      state_nxt = CN_WAIT_FREE;
                    else if (cd_s == 2'b11) state_nxt = CN_LINKED;
                end
                CN_LINKED:     state_nxt = CN_LINKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        link_en = (state == CN_LINKED) && pwr_good;
    end

    genvar ln;
    generate
        for (ln = 0; ln < NUM_LINES; ln++) begin : g_line
            hs_line_join #(.SYNC_STAGES(SYNC_STAGES)) u_join (
                .clk(clk), .rst_n(rst_n), .en(link_en),
                .bp_lvl(bp_s[ln]), .cd_lvl(cd_s[ln]),
                .pd_bp(pd_bp[ln]), .pd_cd(pd_cd[ln]));
        end
    endgenerate

    assign bp_sda_pd = pd_bp[LINE_SDA];
    assign bp_scl_pd = pd_bp[LINE_SCL];
    assign cd_sda_pd = pd_cd[LINE_SDA];
    assign cd_scl_pd = pd_cd[LINE_SCL];

    // R1: supply loss forces lockout at the next edge
    a_r1_lockout_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state == CN_LOCKOUT));
    // R4: connect only follows a cycle with both card lines high
    a_r4_card_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_en) |-> $past(cd_s == 2'b11));
    // R2: connect only from the card-check state
    a_r2_via_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_en) |-> $past(state) == CN_CHECK_CARD);
    // R5: backplane activity during card check restarts the wait
    a_r5_busy_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && state == CN_CHECK_CARD && bp_s != 2'b11) |=> (state != CN_LINKED));
    // R9: no pull-down without a link
    a_r9_no_pd_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |-> (pd_bp == '0 && pd_cd == '0));
endmodule

// File: tb/hs_bus_connect_tb.sv
module hs_bus_connect_tb;
    localparam int IDLE = 20;

    logic clk = 0, rst_n = 0, pwr_good = 0;
    logic bx_sda = 1, bx_scl = 1, cx_sda = 1, cx_scl = 1;
    logic bp_sda, bp_scl, cd_sda, cd_scl;
    logic link_en, bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd;
    int n_run = 0, n_fail = 0;
    int seed_init;

    always #10 clk = ~clk;

    assign bp_sda = bx_sda & ~bp_sda_pd;
    assign bp_scl = bx_scl & ~bp_scl_pd;
    assign cd_sda = cx_sda & ~cd_sda_pd;
    assign cd_scl = cx_scl & ~cd_scl_pd;

    hs_bus_connect #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
        .link_en(link_en), .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
        .cd_sda_pd(cd_sda_pd), .cd_scl_pd(cd_scl_pd));

    function automatic logic wired(input logic a, input logic b);
        return a & b;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_no_pd(input string req);
        chk(req, bp_sda_pd | bp_scl_pd | cd_sda_pd | cd_scl_pd, 1'b0);
    endtask

    task automatic drive(input logic bs, input logic bc, input logic cs, input logic cc);
        bx_sda = bs; bx_scl = bc; cx_sda = cs; cx_scl = cc;
    endtask

    task automatic bp_stop();
        bx_scl = 0; bx_sda = 0; step(3);
        bx_scl = 1; step(3);
        bx_sda = 1;
    endtask

    task automatic check_levels(input string req);
        chk(req, bp_sda, wired(bx_sda, cx_sda));
        chk(req, cd_sda, wired(bx_sda, cx_sda));
        chk(req, bp_scl, wired(bx_scl, cx_scl));
        chk(req, cd_scl, wired(bx_scl, cx_scl));
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        seed_init = $urandom(32'h5eed_1c2c);
        step(3);
        chk("reset", link_en, 1'b0);
        chk_no_pd("reset");
        rst_n = 1;
        step(2);

        // R1: lockout ignores stop and long idle
        bp_stop(); step(2);
        drive(1, 1, 1, 1); step(40);
        chk("R1", link_en, 1'b0);
        chk_no_pd("R1");
        cx_sda = 0; bx_scl = 0; step(5);
        chk_no_pd("R1 lows in lockout");
        drive(1, 1, 1, 1); step(5);
        pwr_good = 1; step(10);
        chk("R1 R3 idle not counted in lockout", link_en, 1'b0);
        step(20);
        chk("R3 idle connects", link_en, 1'b1);

        // R9: supply drop mid-transfer
        bx_sda = 0; step(6);
        chk("R6 bp sda low pulls card", cd_sda_pd, 1'b1);
        @(negedge clk); pwr_good = 0; #1;
        chk("R9 link drops at once", link_en, 1'b0);
        chk_no_pd("R9 pulls released");
        step(3); pwr_good = 1; bx_scl = 0; step(40);
        chk("R2 R9 busy bus no reconnect", link_en, 1'b0);

        // R2: stop connects well before idle
        bx_scl = 1; step(3); bx_sda = 1; step(7);
        chk("R2 stop connects", link_en, 1'b1);

        // R5 / R4: card low, then new transfer during check
        pwr_good = 0; step(2); pwr_good = 1;
        drive(0, 0, 0, 1); step(10);
        bx_scl = 1; step(3); bx_sda = 1; step(8);
        chk("R4 card low blocks link", link_en, 1'b0);
        bx_scl = 0; step(4);
        cx_sda = 1; step(10);
        chk("R5 new transfer restarts wait", link_en, 1'b0);
        bx_sda = 0; bx_scl = 1; step(3); bx_sda = 1; step(7);
        chk("R5 R4 stop plus ready card links", link_en, 1'b1);

        // R6: each direction on each line
        cx_scl = 0; step(6);
        chk("R6 card scl low pulls bp", bp_scl_pd, 1'b1);
        chk("R6 bp scl reads low", bp_scl, 1'b0);
        cx_scl = 1; step(10);
        chk("R8 scl recovers", bp_scl, 1'b1);
        chk_no_pd("R8 no latch after card release");
        cx_sda = 0; step(6);
        chk("R6 card sda low pulls bp", bp_sda_pd, 1'b1);
        bx_sda = 0; step(4); cx_sda = 1; step(12);
        chk("R7 bp still holds sda", cd_sda, 1'b0);
        bx_sda = 1; step(12);
        chk("R8 sda recovers", cd_sda, 1'b1);
        chk_no_pd("R8 no latch");

        // R7: constrained random drivers
        for (int i = 0; i < 60; i++) begin
            drive(($urandom % 4) != 0, ($urandom % 4) != 0,
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
            step(16);
            check_levels("R7 random");
            chk("R7 link held", link_en, 1'b1);
        end
        drive(1, 1, 1, 1); step(16);
        check_levels("R8 final release");
        chk_no_pd("R8 final");

        summary();
        $finish;
    end
endmodule